// File: doc/BRIEF.md
# Step-Down Converter Soft-Start Sequencer

This block controls the start-up and shutdown of a single step-down converter channel. It watches the channel's enable input and a supply-good flag. The supply-good flag means that the input rail is at or above 2.8 V. The block starts a soft start only on a clean enable rising edge that happens while the supply is already good. Each soft start begins at the weakest switch current limit. The limit then doubles in timed steps until it reaches full strength, which keeps in-rush current and start-up stress low.

When the channel is off, the block holds the switch controls in their shutdown states. The high-side switch permit and the bias enable are low, and the low-side discharge path is on so that the output capacitor drains. The block returns the channel to shutdown within one clock when the enable falls or the supply stops being good. This applies at any level of the ramp and after the ramp completes. The analog current comparator, the PWM loop and the switch drivers sit outside this block and use its outputs.

All inputs are assumed to be synchronous to `clk`. Every output is decoded from registered state only.

Top module: `buck_softstart_ctrl`

## Requirements
- R1: `ilim_code_o` selects the switch current limit: 0 means about 213 mA, 1 about 425 mA, 2 about 850 mA and 3 about 1700 mA. While the high-side permit stays high, the code changes only by an increase of exactly one.
- R2: A soft start begins only when `en_i` is sampled low at one clock edge and high at the next, with `supply_ok_i` high at that second edge.
- R3: In shutdown, which is also the reset state, the outputs are `hs_permit_o`=0, `bias_en_o`=0, `discharge_o`=1, `ilim_code_o`=0 and `ramp_done_o`=0.
- R4: In the first cycle after a qualifying start, the outputs are `hs_permit_o`=1, `bias_en_o`=1, `discharge_o`=0 and `ilim_code_o`=0, which is the lowest limit.
- R5: If `supply_ok_i` is sampled low, the outputs are in the shutdown state of R3 from the next cycle onward, whatever the value of `en_i`.
- R6: If `en_i` is sampled low during the ramp or after it completes, the outputs are in the shutdown state from the next cycle.
- R7: Each code below the top code is held for exactly `STEP_CYCLES` clock cycles before the next code appears.
- R8: When code 3 is reached, `ramp_done_o` rises in the same cycle. `ramp_done_o` then stays high, with code 3 and the high-side permit also held, until a shutdown.
- R9: An enable that is already high when reset is released, or when the supply becomes good, does not start the ramp. The enable must go low and then rise again.
- R10: An enable rising edge that happens while `supply_ok_i` is low is discarded. The channel stays in shutdown even after the supply later becomes good with the enable still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulator enable request |
| supply_ok_i | input | 1 | Input supply at or above 2.8 V |
| ilim_code_o | output | $clog2(NUM_LEVELS) | Current-limit level code |
| hs_permit_o | output | 1 | High-side switch permitted to conduct |
| bias_en_o | output | 1 | Reference, control and bias enable |
| discharge_o | output | 1 | Low-side output discharge enable |
| ramp_done_o | output | 1 | Full current limit reached |

## Verification
The bench builds the block with `STEP_CYCLES` set to 8 and `NUM_LEVELS` left at 4. With these values a full ramp takes 24 cycles. That lets the bench test an abort at every level, test both edges of every hold window, and test a long hold at full strength, all in a short run. The default hold of 1024 cycles uses the same counter and compare path, so the bench does not exercise it separately.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [1:0] {
    SS_OFF  = 2'd0,
    SS_RAMP = 2'd1,
    SS_FULL = 2'd2
  } ss_state_e;

  typedef struct packed {
    logic hs_permit;
    logic bias_en;
    logic discharge;
    logic done;
  } ss_drive_t;

  localparam ss_drive_t SS_DRIVE_OFF = '{hs_permit: 1'b0, bias_en: 1'b0,
                                         discharge: 1'b1, done: 1'b0};

endpackage

// File: rtl/ss_enable_qual.sv
module ss_enable_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic supply_ok_i,
  output logic start_o,
  output logic kill_o
);

  // Enable history resets high, so an enable that is already high is never
  // taken as a fresh edge.
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_i;
  end

  assign start_o = en_i & ~en_q & supply_ok_i;
  assign kill_o  = ~en_i | ~supply_ok_i;

endmodule

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
  parameter int unsigned STEP_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick_o = run_i & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear_i) cnt <= '0;
    else if (run_i)   cnt <= tick_o ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/ss_level_fsm.sv
module ss_level_fsm
  import ss_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          kill_i,
  input  logic                          tick_i,
  output ss_state_e                     state_o,
  output logic [$clog2(NUM_LEVELS)-1:0] level_o,
  output logic                          timer_clear_o,
  output logic                          timer_run_o
);

  localparam int unsigned LW = $clog2(NUM_LEVELS);
  localparam logic [LW-1:0] TOP = LW'(NUM_LEVELS - 1);

  ss_state_e     state_q, state_d;
  logic [LW-1:0] level_q, level_d;

  always_comb begin
    state_d = state_q;
    level_d = level_q;
    unique case (state_q)
      SS_OFF: begin
        level_d = '0;
        if (start_i) state_d = SS_RAMP;
      end
      SS_RAMP: begin
        if (kill_i) begin
          state_d = SS_OFF;
          level_d = '0;
        end else if (tick_i) begin
          level_d = level_q + 1'b1;
          if (level_q == TOP - 1'b1) state_d = SS_FULL;
        end
      end
      SS_FULL: begin
        if (kill_i) begin
          state_d = SS_OFF;
          level_d = '0;
        end
      end
      default: begin
        state_d = SS_OFF;
        level_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SS_OFF;
      level_q <= '0;
    end else begin
      state_q <= state_d;
      level_q <= level_d;
    end
  end

  assign state_o       = state_q;
  assign level_o       = level_q;
  assign timer_run_o   = (state_q == SS_RAMP);
  assign timer_clear_o = (state_q != SS_RAMP) | kill_i;

endmodule

// File: rtl/ss_out_decode.sv
module ss_out_decode
  import ss_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 4
) (
  input  ss_state_e                     state_i,
  input  logic [$clog2(NUM_LEVELS)-1:0] level_i,
  output logic [$clog2(NUM_LEVELS)-1:0] ilim_code_o,
  output ss_drive_t                     drive_o
);

  always_comb begin
    drive_o     = SS_DRIVE_OFF;
    ilim_code_o = '0;
    if (state_i != SS_OFF) begin
      drive_o.hs_permit = 1'b1;
      drive_o.bias_en   = 1'b1;
      drive_o.discharge = 1'b0;
      drive_o.done      = (state_i == SS_FULL);
      ilim_code_o       = level_i;
    end
  end

endmodule

// File: rtl/buck_softstart_ctrl.sv
module buck_softstart_ctrl
  import ss_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 1024,
  parameter int unsigned NUM_LEVELS  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_i,
  input  logic                          supply_ok_i,
  output logic [$clog2(NUM_LEVELS)-1:0] ilim_code_o,
  output logic                          hs_permit_o,
  output logic                          bias_en_o,
  output logic                          discharge_o,
  output logic                          ramp_done_o
);

  localparam int unsigned LW = $clog2(NUM_LEVELS);

  logic          start, kill, tick, t_clear, t_run;
  ss_state_e     state;
  logic [LW-1:0] level;
  ss_drive_t     drive;

  ss_enable_qual u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .supply_ok_i(supply_ok_i),
    .start_o    (start),
    .kill_o     (kill)
  );

  ss_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(t_clear),
    .run_i  (t_run),
    .tick_o (tick)
  );

  ss_level_fsm #(.NUM_LEVELS(NUM_LEVELS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .kill_i       (kill),
    .tick_i       (tick),
    .state_o      (state),
    .level_o      (level),
    .timer_clear_o(t_clear),
    .timer_run_o  (t_run)
  );

  ss_out_decode #(.NUM_LEVELS(NUM_LEVELS)) u_dec (
    .state_i    (state),
    .level_i    (level),
    .ilim_code_o(ilim_code_o),
    .drive_o    (drive)
  );

  assign hs_permit_o = drive.hs_permit;
  assign bias_en_o   = drive.bias_en;
  assign discharge_o = drive.discharge;
  assign ramp_done_o = drive.done;

endmodule

// File: rtl/ss_ctrl_chk.sv
module ss_ctrl_chk #(
  parameter int unsigned STEP_CYCLES = 1024,
  parameter int unsigned NUM_LEVELS  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          en_i,
  input logic                          supply_ok_i,
  input logic [$clog2(NUM_LEVELS)-1:0] ilim_code_o,
  input logic                          hs_permit_o,
  input logic                          bias_en_o,
  input logic                          discharge_o,
  input logic                          ramp_done_o
);

  localparam int unsigned LW = $clog2(NUM_LEVELS);
  localparam int unsigned HW = $clog2(STEP_CYCLES + 2) + 1;
  localparam logic [HW-1:0] HMAX = '1;

  logic          en_d1, hs_d;
  logic [LW-1:0] code_d;
  logic [HW-1:0] hold_cnt;

  // Own history: enable before the last edge, and how many cycles the
  // current code has been shown with the high-side permit up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d1    <= 1'b1;
      hs_d     <= 1'b0;
      code_d   <= '0;
      hold_cnt <= '0;
    end else begin
      en_d1  <= en_i;
      hs_d   <= hs_permit_o;
      code_d <= ilim_code_o;
      if (!hs_permit_o)                              hold_cnt <= '0;
      else if (!hs_d || ilim_code_o != code_d)        hold_cnt <= HW'(1);
      else if (hold_cnt != HMAX)                      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assert_code_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_permit_o && hs_d && ilim_code_o != code_d) |-> (ilim_code_o == LW'(code_d + 1'b1)));

  assert_qualified_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(discharge_o) |-> ($past(en_i) && !$past(en_d1) && $past(supply_ok_i)));

  assert_off_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    discharge_o |-> (!hs_permit_o && !bias_en_o && ilim_code_o == '0 && !ramp_done_o));

  assert_lowest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_permit_o) |-> (ilim_code_o == '0 && bias_en_o));

  assert_supply_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> discharge_o);

  assert_enable_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (discharge_o && !hs_permit_o));

  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_permit_o && hs_d && ilim_code_o != code_d) |-> (hold_cnt == HW'(STEP_CYCLES)));

  assert_done_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done_o |-> (ilim_code_o == LW'(NUM_LEVELS - 1) && hs_permit_o));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_done_o && en_i && supply_ok_i) |=> ramp_done_o);

endmodule

bind buck_softstart_ctrl ss_ctrl_chk #(
  .STEP_CYCLES(STEP_CYCLES),
  .NUM_LEVELS (NUM_LEVELS)
) u_ss_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .supply_ok_i(supply_ok_i),
  .ilim_code_o(ilim_code_o),
  .hs_permit_o(hs_permit_o),
  .bias_en_o  (bias_en_o),
  .discharge_o(discharge_o),
  .ramp_done_o(ramp_done_o)
);

// File: tb/test_buck_softstart_ctrl.sv
module test_buck_softstart_ctrl;

  localparam int unsigned S  = 8;
  localparam int unsigned NL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic       supply_ok_i = 1'b0;
  logic [1:0] ilim_code_o;
  logic       hs_permit_o, bias_en_o, discharge_o, ramp_done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  buck_softstart_ctrl #(.STEP_CYCLES(S), .NUM_LEVELS(NL)) i_buck_softstart_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .supply_ok_i(supply_ok_i),
    .ilim_code_o(ilim_code_o),
    .hs_permit_o(hs_permit_o),
    .bias_en_o  (bias_en_o),
    .discharge_o(discharge_o),
    .ramp_done_o(ramp_done_o)
  );

  // Packed view: {code[1:0], hs, bias, discharge, done}
  function automatic logic [5:0] exp_off();
    return {2'd0, 1'b0, 1'b0, 1'b1, 1'b0};
  endfunction

  function automatic logic [5:0] exp_run(input logic [1:0] code);
    return {code, 1'b1, 1'b1, 1'b0, (code == 2'd3)};
  endfunction

  task automatic check(input logic [5:0] expv, input string req);
    logic [5:0] act;
    act = {ilim_code_o, hs_permit_o, bias_en_o, discharge_o, ramp_done_o};
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Leaves the bench one negedge after the qualifying edge (first ramp cycle).
  task automatic kick();
    en_i = 1'b0;
    step(1);
    en_i = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    supply_ok_i = 1'b1;
    en_i = 1'b1;
    step(3);
    check(exp_off(), "R3 reset state");
    rst_n = 1'b1;
    step(4);
    check(exp_off(), "R9 enable high at reset release");
  endtask

  task automatic t_full_ramp();
    kick();
    check(exp_run(2'd0), "R4 first cycle lowest limit");
    step(S - 1);
    check(exp_run(2'd0), "R7 level 0 last cycle");
    step(1);
    check(exp_run(2'd1), "R1 level 1");
    step(S - 1);
    check(exp_run(2'd1), "R7 level 1 last cycle");
    step(1);
    check(exp_run(2'd2), "R1 level 2");
    step(S - 1);
    check(exp_run(2'd2), "R7 level 2 last cycle");
    step(1);
    check(exp_run(2'd3), "R8 full limit and done");
    step(40);
    check(exp_run(2'd3), "R8 done held");
    en_i = 1'b0;
    step(1);
    check(exp_off(), "R6 enable drop from done");
  endtask

  task automatic t_supply_abort();
    kick();
    step(S + 2);
    check(exp_run(2'd1), "R1 mid ramp before supply loss");
    supply_ok_i = 1'b0;
    step(1);
    check(exp_off(), "R5 supply loss in ramp");
    supply_ok_i = 1'b1;
    step(4);
    check(exp_off(), "R9 supply back with enable held high");
    kick();
    check(exp_run(2'd0), "R2 restart after new edge");
    step(3 * S);
    check(exp_run(2'd3), "R8 done after restart");
    supply_ok_i = 1'b0;
    step(1);
    check(exp_off(), "R5 supply loss from done");
    supply_ok_i = 1'b1;
    en_i = 1'b0;
    step(2);
  endtask

  task automatic t_enable_abort();
    kick();
    step(2 * S + 3);
    check(exp_run(2'd2), "R1 level 2 before enable drop");
    en_i = 1'b0;
    step(1);
    check(exp_off(), "R6 enable drop in ramp");
    step(3);
    check(exp_off(), "R3 stays off with enable low");
  endtask

  task automatic t_enable_before_supply();
    supply_ok_i = 1'b0;
    en_i = 1'b0;
    step(2);
    en_i = 1'b1;
    step(3);
    check(exp_off(), "R10 edge while supply low");
    supply_ok_i = 1'b1;
    step(5);
    check(exp_off(), "R9 supply good with enable already high");
    kick();
    check(exp_run(2'd0), "R2 start after fresh edge");
    en_i = 1'b0;
    step(2);
  endtask

  task automatic t_same_edge_supply();
    // Enable and supply both rise at one edge: enable was low before, supply ok at that edge.
    supply_ok_i = 1'b0;
    en_i = 1'b0;
    step(2);
    en_i = 1'b1;
    supply_ok_i = 1'b1;
    step(1);
    check(exp_run(2'd0), "R2 edge with supply good at same edge");
    supply_ok_i = 1'b0;
    step(1);
    check(exp_off(), "R5 supply drop in first level");
    en_i = 1'b0;
    supply_ok_i = 1'b1;
    step(2);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(1);
    t_reset();
    t_full_ramp();
    t_supply_abort();
    t_enable_abort();
    t_enable_before_supply();
    t_same_edge_supply();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule